// File: doc/BRIEF.md
# Interrupt Cause Aggregation Controller

This block gathers interrupt events from three sources (RX, TX and MISC) into one interrupt line. Each source has a unit of 32 cause bits. A hardware event pulse sets a cause bit. Software can also force cause bits to 1. Each cause bit has its own mask bit, and each bit can be switched at run time between two clearing modes: it is cleared either by a read of the cause register, or by writing a 1 to its position.

Above the three units sits a pseudo-cause register. It holds one summary bit per unit. A summary bit is set when that unit has any pending cause whose mask bit is clear. Reading the pseudo-cause register clears it. The pseudo-cause register has its own software mask, and the interrupt output is raised while any summary bit is set and not masked.

All registers sit on a simple single-cycle bus. Read data is combinational from the address. Writes, and the clearing effect of reads, take effect at the next rising clock edge. A handler reads the pseudo-cause register, then services and clears the unit causes that it flags.

Top module: `irq_agg_top`

## Requirements
- R1: Synchronous active-high reset gives the following state: every cause bit 0, every clear-control bit 0, every unit mask bit 1, the pseudo-cause register 0, every pseudo-mask bit 1, and `irq_out` low.
- R2: A 1 on `hw_evt` bit 32*u+i sets cause bit i of unit u at the next clock edge (unit 0 is RX, 1 is TX, 2 is MISC). When an event and any software clear hit the same bit in the same cycle, the bit ends up set.
- R3: For a cause bit whose clear-control bit is 0, writing 1 to its position in the cause register (offset 0) clears it, and writing 0 leaves it unchanged. A cause bit whose clear-control bit is 1 is not changed by writes to the cause register.
- R4: The clear-control register (offset 2) can be read and written; a 1 selects clear-on-read for that cause bit. A read of the cause register returns the value the register held before the read, and clears every cause bit whose clear-control bit is 1.
- R5: Writing to the set-cause register (offset 1) sets to 1 every cause bit at a position where the written data has a 1.
- R6: Writing the mask-set register (offset 3) sets the mask bits at the 1 positions of the data. Writing the mask-clear register (offset 4) clears the mask bits at those positions. Offsets 3, 4 and the read-only offset 6 all read back the current mask. Masking a bit does not change its cause bit.
- R7: Offset 5 is a read-only view of the cause register ANDed with the inverted mask.
- R8: Pseudo-cause bit 0 belongs to RX, bit 1 to TX and bit 2 to MISC. Each bit is set at the clock edge that ends a cycle in which its unit has an unmasked pending cause. The bit then stays set until the pseudo-cause register is read.
- R9: A read of the pseudo-cause register returns its value and clears it at that edge. A bit whose unit is still pending is set again at the following edge.
- R10: The pseudo-mask register can be read and written; only its low three bits gate anything. `irq_out` is high exactly while some pseudo-cause bit is set and its pseudo-mask bit is 0.
- R11: Address bits [7:3] select a group: 0 for RX, 1 for TX, 2 for MISC, 4 for the top level. Bits [2:0] select the register. In group 4, offset 0 is the pseudo-cause register and offset 1 is the pseudo-mask. The set-cause register, unit offset 7, and unmapped top-level offsets all read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for the clear-on-read side effects) |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| hw_evt | input | 96 | Event pulses, 32 per unit, with RX in the lowest 32 bits |
| irq_out | output | 1 | Interrupt line |

## Verification
The assertions check the following on every cycle:
- Reset values are reached.
- Every event bit appears in its cause register one edge later, whatever software does in that cycle.
- Masks do not move when no write occurs.
- A pseudo-cause read always empties the register.
- A pseudo-cause bit rises only after its unit was pending.
- A fully masked pseudo-cause register keeps the line low.

Only the bench scenarios can show the following:
- The exact read-back values.
- The difference between the two clearing modes, including bits of different modes mixed in one unit.
- The re-set of a pseudo-cause bit after it has been read.
- That writes of 0 and writes to clear-on-read bits have no effect.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Low address bits pick the register inside a group.
    localparam int OFS_W     = 3;
    // Group index of the top-level pseudo-cause registers.
    localparam int TOP_GROUP = 4;

    typedef enum logic [OFS_W-1:0] {
        UREG_CAUSE   = 3'd0,
        UREG_SETC    = 3'd1,
        UREG_CLRCTL  = 3'd2,
        UREG_MSET    = 3'd3,
        UREG_MCLR    = 3'd4,
        UREG_MCAUSE  = 3'd5,
        UREG_MVAL    = 3'd6,
        UREG_UNUSED  = 3'd7
    } unit_reg_e;

    typedef enum logic [OFS_W-1:0] {
        TREG_PCAUSE  = 3'd0,
        TREG_PMASK   = 3'd1
    } top_reg_e;

    // One access as seen by one register group.
    typedef struct packed {
        logic      wr;
        logic      rd;
        unit_reg_e sel;
    } unit_acc_t;

    // True when the group field of an address equals grp.
    function automatic logic group_hit(input logic [7:0] addr, input int grp);
        return (int'(addr[7:OFS_W]) == grp);
    endfunction

endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
#(
    parameter int NUM_UNITS = 3
) (
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [7:0]                 bus_addr,
    output unit_acc_t [NUM_UNITS-1:0]  unit_acc,
    output logic                       pc_rd,
    output logic                       pm_wr
);

    logic top_sel;

    assign top_sel = group_hit(bus_addr, TOP_GROUP);
    assign pc_rd   = bus_rd && top_sel && (bus_addr[OFS_W-1:0] == TREG_PCAUSE);
    assign pm_wr   = bus_wr && top_sel && (bus_addr[OFS_W-1:0] == TREG_PMASK);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_dec
        logic hit;
        assign hit             = group_hit(bus_addr, u);
        assign unit_acc[u].wr  = bus_wr && hit;
        assign unit_acc[u].rd  = bus_rd && hit;
        assign unit_acc[u].sel = unit_reg_e'(bus_addr[OFS_W-1:0]);
    end

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
    import irq_agg_pkg::*;
#(
    parameter int CAUSE_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  unit_acc_t          acc,
    input  logic [CAUSE_W-1:0] wdata,
    input  logic [CAUSE_W-1:0] evt,
    output logic [CAUSE_W-1:0] rdata,
    output logic [CAUSE_W-1:0] cause_o,
    output logic [CAUSE_W-1:0] mask_o,
    output logic               pending
);

    logic [CAUSE_W-1:0] cause_q, mask_q, cor_q;
    logic [CAUSE_W-1:0] clr_w1c, clr_cor, set_sw, cause_d;
    logic               wr_cause, rd_cause, wr_set, wr_ctl, wr_mset, wr_mclr;

    assign wr_cause = acc.wr && (acc.sel == UREG_CAUSE);
    assign rd_cause = acc.rd && (acc.sel == UREG_CAUSE);
    assign wr_set   = acc.wr && (acc.sel == UREG_SETC);
    assign wr_ctl   = acc.wr && (acc.sel == UREG_CLRCTL);
    assign wr_mset  = acc.wr && (acc.sel == UREG_MSET);
    assign wr_mclr  = acc.wr && (acc.sel == UREG_MCLR);

    // Write-1 clears only reach bits in W1C mode; reads only clear COR bits.
    assign clr_w1c = wr_cause ? (wdata & ~cor_q) : '0;
    assign clr_cor = rd_cause ? cor_q : '0;
    assign set_sw  = wr_set ? wdata : '0;
    // Events are ORed in last so they win over any same-cycle clear.
    assign cause_d = (cause_q & ~(clr_w1c | clr_cor)) | set_sw | evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
            mask_q  <= '1;
            cor_q   <= '0;
        end else begin
            cause_q <= cause_d;
            if (wr_ctl)
                cor_q <= wdata;
            if (wr_mset)
                mask_q <= mask_q | wdata;
            else if (wr_mclr)
                mask_q <= mask_q & ~wdata;
        end
    end

    always_comb begin
        unique case (acc.sel)
            UREG_CAUSE:  rdata = cause_q;
            UREG_CLRCTL: rdata = cor_q;
            UREG_MSET,
            UREG_MCLR,
            UREG_MVAL:   rdata = mask_q;
            UREG_MCAUSE: rdata = cause_q & ~mask_q;
            default:     rdata = '0;
        endcase
    end

    assign cause_o = cause_q;
    assign mask_o  = mask_q;
    assign pending = |(cause_q & ~mask_q);

endmodule

// File: rtl/irq_pseudo_cause.sv
module irq_pseudo_cause #(
    parameter int NUM_UNITS = 3,
    parameter int CAUSE_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_UNITS-1:0] unit_pend,
    input  logic                 pc_rd,
    input  logic                 pm_wr,
    input  logic [CAUSE_W-1:0]   wdata,
    output logic [NUM_UNITS-1:0] pc_q,
    output logic [CAUSE_W-1:0]   pm_q,
    output logic                 irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            pm_q <= '1;
        end else begin
            // A read empties the register; pending units refill it one edge later.
            pc_q <= pc_rd ? '0 : (pc_q | unit_pend);
            if (pm_wr)
                pm_q <= wdata;
        end
    end

    assign irq = |(pc_q & ~pm_q[NUM_UNITS-1:0]);

endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int NUM_UNITS = 3,
    parameter int CAUSE_W   = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic                           bus_rd,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [CAUSE_W-1:0]             bus_wdata,
    output logic [CAUSE_W-1:0]             bus_rdata,
    input  logic [NUM_UNITS*CAUSE_W-1:0]   hw_evt,
    output logic                           irq_out
);

    localparam int ALL_W = NUM_UNITS * CAUSE_W;

    unit_acc_t [NUM_UNITS-1:0]  unit_acc;
    logic [CAUSE_W-1:0]         unit_rdata [NUM_UNITS];
    logic [ALL_W-1:0]           cause_all, mask_all;
    logic [NUM_UNITS-1:0]       unit_pend;
    logic [NUM_UNITS-1:0]       pc_q;
    logic [CAUSE_W-1:0]         pm_q;
    logic                       pc_rd, pm_wr;

    irq_agg_decode #(.NUM_UNITS(NUM_UNITS)) dec_i (
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr[7:0]),
        .unit_acc (unit_acc),
        .pc_rd    (pc_rd),
        .pm_wr    (pm_wr)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        irq_cause_unit #(.CAUSE_W(CAUSE_W)) unit_i (
            .clk     (clk),
            .rst     (rst),
            .acc     (unit_acc[u]),
            .wdata   (bus_wdata),
            .evt     (hw_evt[u*CAUSE_W +: CAUSE_W]),
            .rdata   (unit_rdata[u]),
            .cause_o (cause_all[u*CAUSE_W +: CAUSE_W]),
            .mask_o  (mask_all[u*CAUSE_W +: CAUSE_W]),
            .pending (unit_pend[u])
        );
    end

    irq_pseudo_cause #(.NUM_UNITS(NUM_UNITS), .CAUSE_W(CAUSE_W)) pc_i (
        .clk       (clk),
        .rst       (rst),
        .unit_pend (unit_pend),
        .pc_rd     (pc_rd),
        .pm_wr     (pm_wr),
        .wdata     (bus_wdata),
        .pc_q      (pc_q),
        .pm_q      (pm_q),
        .irq       (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (group_hit(bus_addr[7:0], u))
                bus_rdata = unit_rdata[u];
        end
        if (group_hit(bus_addr[7:0], TOP_GROUP)) begin
            if (bus_addr[OFS_W-1:0] == TREG_PCAUSE)
                bus_rdata = CAUSE_W'(pc_q);
            else if (bus_addr[OFS_W-1:0] == TREG_PMASK)
                bus_rdata = pm_q;
        end
    end

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int NUM_UNITS = 3,
    parameter int CAUSE_W   = 32
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_wr,
    input logic [NUM_UNITS*CAUSE_W-1:0] hw_evt,
    input logic                         irq_out,
    input logic [NUM_UNITS*CAUSE_W-1:0] cause_all,
    input logic [NUM_UNITS*CAUSE_W-1:0] mask_all,
    input logic [NUM_UNITS-1:0]         pc_q,
    input logic [CAUSE_W-1:0]           pm_q,
    input logic [NUM_UNITS-1:0]         unit_pend,
    input logic                         pc_rd
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cause_all == '0 && mask_all == '1 && pc_q == '0 && pm_q == '1));

    assert_event_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (|hw_evt) |=> ((cause_all & $past(hw_evt)) == $past(hw_evt)));

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(mask_all));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
        pc_rd |=> (pc_q == '0));

    assert_full_mask_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (pm_q[NUM_UNITS-1:0] == '1) |-> !irq_out);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_pc
        assert_pc_source_R8: assert property (@(posedge clk) disable iff (rst)
            $rose(pc_q[u]) |-> $past(unit_pend[u]));
    end

endmodule

bind irq_agg_top irq_agg_chk #(.NUM_UNITS(NUM_UNITS), .CAUSE_W(CAUSE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .hw_evt    (hw_evt),
    .irq_out   (irq_out),
    .cause_all (cause_all),
    .mask_all  (mask_all),
    .pc_q      (pc_q),
    .pm_q      (pm_q),
    .unit_pend (unit_pend),
    .pc_rd     (pc_rd)
);

// File: tb/irq_agg_top_tb_top.sv
module irq_agg_top_tb_top;

    localparam int NU = 3;
    localparam int CW = 32;

    localparam logic [2:0] OP_WR   = 3'd0;
    localparam logic [2:0] OP_RD   = 3'd1;
    localparam logic [2:0] OP_EV   = 3'd2;
    localparam logic [2:0] OP_IRQ  = 3'd3;
    localparam logic [2:0] OP_WREV = 3'd4;
    localparam logic [2:0] OP_IDLE = 3'd5;

    localparam int NV = 55;
    // {op, addr, data, expected, requirement}
    localparam logic [78:0] VEC [NV] = '{
        {OP_RD,   8'h00, 32'h0,        32'h0,        4'd1},  // R1 cause
        {OP_RD,   8'h06, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 mask
        {OP_RD,   8'h02, 32'h0,        32'h0,        4'd1},  // R1 ctl
        {OP_RD,   8'h21, 32'h0,        32'hFFFFFFFF, 4'd1},  // R1 pmask
        {OP_RD,   8'h20, 32'h0,        32'h0,        4'd1},  // R1 pcause
        {OP_IRQ,  8'h00, 32'h0,        32'h0,        4'd1},  // R1 line
        {OP_EV,   8'h00, 32'h11,       32'h0,        4'd2},  // R2
        {OP_RD,   8'h00, 32'h0,        32'h11,       4'd2},  // R2
        {OP_RD,   8'h05, 32'h0,        32'h0,        4'd7},  // R7
        {OP_WR,   8'h04, 32'h1,        32'h0,        4'd6},  // R6 unmask
        {OP_RD,   8'h06, 32'h0,        32'hFFFFFFFE, 4'd6},  // R6
        {OP_RD,   8'h05, 32'h0,        32'h1,        4'd7},  // R7
        {OP_RD,   8'h20, 32'h0,        32'h1,        4'd8},  // R8
        {OP_RD,   8'h20, 32'h0,        32'h0,        4'd9},  // R9 cleared
        {OP_IDLE, 8'h00, 32'h0,        32'h0,        4'd9},
        {OP_RD,   8'h20, 32'h0,        32'h1,        4'd9},  // R9 re-set
        {OP_WR,   8'h21, 32'hFFFFFFF8, 32'h0,        4'd10}, // R10
        {OP_IRQ,  8'h00, 32'h0,        32'h1,        4'd10}, // R10
        {OP_WR,   8'h00, 32'h10,       32'h0,        4'd3},  // R3
        {OP_RD,   8'h00, 32'h0,        32'h1,        4'd3},  // R3
        {OP_WR,   8'h00, 32'h0,        32'h0,        4'd3},  // R3 zero
        {OP_RD,   8'h00, 32'h0,        32'h1,        4'd3},  // R3
        {OP_WR,   8'h00, 32'h1,        32'h0,        4'd3},  // R3
        {OP_RD,   8'h00, 32'h0,        32'h0,        4'd3},  // R3
        {OP_RD,   8'h20, 32'h0,        32'h1,        4'd8},  // R8 sticky
        {OP_IRQ,  8'h00, 32'h0,        32'h0,        4'd10}, // R10
        {OP_WR,   8'h0A, 32'hF,        32'h0,        4'd4},  // R4
        {OP_RD,   8'h0A, 32'h0,        32'hF,        4'd4},  // R4
        {OP_WR,   8'h09, 32'h101,      32'h0,        4'd5},  // R5
        {OP_RD,   8'h08, 32'h0,        32'h101,      4'd5},  // R5
        {OP_RD,   8'h08, 32'h0,        32'h100,      4'd4},  // R4
        {OP_WR,   8'h08, 32'h100,      32'h0,        4'd3},  // R3
        {OP_RD,   8'h08, 32'h0,        32'h0,        4'd3},  // R3
        {OP_WR,   8'h09, 32'h2,        32'h0,        4'd5},  // R5
        {OP_WR,   8'h08, 32'h2,        32'h0,        4'd3},  // R3 COR ignores
        {OP_RD,   8'h08, 32'h0,        32'h2,        4'd3},  // R3
        {OP_RD,   8'h08, 32'h0,        32'h0,        4'd4},  // R4
        {OP_WR,   8'h14, 32'h80000000, 32'h0,        4'd6},  // R6
        {OP_EV,   8'h10, 32'h80000000, 32'h0,        4'd2},  // R2
        {OP_RD,   8'h15, 32'h0,        32'h80000000, 4'd7},  // R7
        {OP_IRQ,  8'h00, 32'h0,        32'h1,        4'd8},  // R8
        {OP_RD,   8'h20, 32'h0,        32'h4,        4'd8},  // R8 MISC
        {OP_WR,   8'h13, 32'h80000000, 32'h0,        4'd6},  // R6
        {OP_RD,   8'h20, 32'h0,        32'h4,        4'd9},  // R9
        {OP_RD,   8'h20, 32'h0,        32'h0,        4'd6},  // R6
        {OP_RD,   8'h16, 32'h0,        32'hFFFFFFFF, 4'd6},  // R6
        {OP_RD,   8'h15, 32'h0,        32'h0,        4'd7},  // R7
        {OP_RD,   8'h10, 32'h0,        32'h80000000, 4'd6},  // R6 cause kept
        {OP_EV,   8'h00, 32'h4,        32'h0,        4'd2},  // R2
        {OP_WREV, 8'h00, 32'h4,        32'h0,        4'd2},  // R2 collision
        {OP_RD,   8'h00, 32'h0,        32'h4,        4'd2},  // R2
        {OP_WR,   8'h00, 32'h4,        32'h0,        4'd3},  // R3
        {OP_RD,   8'h00, 32'h0,        32'h0,        4'd3},  // R3
        {OP_RD,   8'h07, 32'h0,        32'h0,        4'd11}, // R11
        {OP_RD,   8'h09, 32'h0,        32'h0,        4'd11}  // R11
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_wr = 1'b0;
    logic               bus_rd = 1'b0;
    logic [7:0]         bus_addr = '0;
    logic [CW-1:0]      bus_wdata = '0;
    logic [CW-1:0]      bus_rdata;
    logic [NU*CW-1:0]   hw_evt = '0;
    logic               irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_agg_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_evt    (hw_evt),
        .irq_out   (irq_out)
    );

    task automatic check(input int req, input logic [CW-1:0] got, input logic [CW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: got %08h expected %08h at %0t", req, got, exp, $time);
        end
    endtask

    // One step: drive after a falling edge, check before the rising edge.
    task automatic step(input logic [2:0] op, input logic [7:0] addr,
                        input logic [CW-1:0] data, input logic [CW-1:0] exp, input int req);
        @(negedge clk);
        bus_wr = (op == OP_WR) || (op == OP_WREV);
        bus_rd = (op == OP_RD);
        bus_addr = addr;
        bus_wdata = data;
        hw_evt = '0;
        if (op == OP_EV || op == OP_WREV)
            hw_evt[int'(addr[7:3])*CW +: CW] = data;
        #1;
        if (op == OP_RD)
            check(req, bus_rdata, exp);
        else if (op == OP_IRQ)
            check(req, {31'b0, irq_out}, exp);
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        hw_evt = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NV; i++)
            step(VEC[i][78:76], VEC[i][75:68], VEC[i][67:36], VEC[i][35:4], int'(VEC[i][3:0]));

        // R1: reset in mid-run returns every register to its reset value.
        step(OP_WR, 8'h0A, 32'h5, 32'h0, 1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        step(OP_RD, 8'h10, 32'h0, 32'h0, 1);          // R1 MISC cause
        step(OP_RD, 8'h16, 32'h0, 32'hFFFFFFFF, 1);   // R1 MISC mask
        step(OP_RD, 8'h0A, 32'h0, 32'h0, 1);          // R1 TX ctl
        step(OP_RD, 8'h21, 32'h0, 32'hFFFFFFFF, 1);   // R1 pmask
        step(OP_IRQ, 8'h00, 32'h0, 32'h0, 1);         // R1 line

        // R11: an unmapped top-level offset reads 0.
        step(OP_RD, 8'h22, 32'h0, 32'h0, 11);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule